// File: doc/BRIEF.md
# MSI Termination and Pending Aggregator

This block terminates message-signalled interrupt writes coming out of a PCIe root port. Each write carries an address and a data word. The address picks one of 128 pending registers, arranged as 16 termination groups of 8 index registers each. The low data bits pick one of the 16 pending bits in that register. Across all registers that gives 2048 vectors.

For each group the block derives a summary showing which of its index registers are non-empty. It also drives one interrupt line per group, 16 lines in all. Software services a group as follows: it reads the summary to find the busy index registers, then reads each of those registers. A read of an index register returns its pending bits and clears them in one step.

A vector v is delivered by writing to index register v/256 of group (v mod 256)/16, with data v mod 16. So a vector's group, and with it the interrupt line it raises, is chosen by bits 7:4 of the vector number.

Top module: `msi_pend_agg`

## Requirements
- R1: A synchronous active-high `rst` clears every pending bit. After the edge that samples it, `irq` is all zero and `rd_valid` is low.
- R2: A write to offset (g*8+i)*0x10000, for g in 0..15 and i in 0..7, sets bit `wr_data[3:0]` of index register i of group g. Data bits above bit 3 have no effect.
- R3: A write that sets a bit which is already pending changes nothing. The register reads back with that bit once, and no other bit changes.
- R4: A read at offset 0x800000 + g*0x10000 returns the summary of group g. Bit i of the summary is 1 exactly when index register i of group g is non-zero, and bits 15:8 read 0.
- R5: `irq[g]` is high exactly while some index register of group g is non-zero. It rises on the clock edge that samples the setting write.
- R6: A read is answered on the edge after `rd_en`, with `rd_valid` high for one cycle per read. A read of an index register returns its value and clears it on that edge, so the group's summary bit and its `irq` line drop at the same time if nothing else is pending.
- R7: If a write sets a bit in the same cycle that a read clears the same register, the read returns the old contents and the newly written bit stays pending.
- R8: Reading a summary register changes no pending state.
- R9: Writes to summary offsets, to offsets whose low 16 bits are not zero, and to offsets at or above 0x900000 are ignored. Reads of such unmapped offsets return 0.
- R10: For every vector v in 0..2047, a write of data v mod 16 to index register v/256 of group (v mod 256)/16 raises `irq[(v mod 256)/16]`. The matching index register then reads back as the single bit v mod 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Message write strobe |
| wr_addr | input | 24 | Message write offset |
| wr_data | input | 32 | Message data; bits 3:0 select the vector bit |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 24 | Register read offset |
| rd_data | output | 16 | Read result, valid with `rd_valid` |
| rd_valid | output | 1 | High on the cycle after each `rd_en` |
| irq | output | 16 | One interrupt line per termination group |

## Verification
A pending bit that lands in the wrong register shows up in two ways. On the very next cycle it raises the wrong `irq` line. Later, the summary and index reads of the intended group come back with the wrong values. A clear that misses its target, or hits the wrong one, leaves an interrupt line high after the service read. A second read of the same register then returns a non-zero value instead of zero. The bench keeps its own image of all 128 registers, so every read and every interrupt sample is compared against it at once, and a wrong bit is caught within one cycle of the access that exposes it.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;

  // Classification of an offset seen on either port.
  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_TERM = 2'd1,
    HIT_SUM  = 2'd2
  } hit_e;

endpackage

// File: rtl/msi_addr_decode.sv
module msi_addr_decode
  import msi_agg_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int STRIDE_LOG2 = 16,
  parameter int N_GRP       = 16,
  parameter int N_IDX       = 8
) (
  input  logic [ADDR_W-1:0]          addr,
  output hit_e                       kind,
  output logic [$clog2(N_GRP)-1:0]   grp,
  output logic [$clog2(N_IDX)-1:0]   idx
);
  localparam int SLOT_W = ADDR_W - STRIDE_LOG2;
  localparam int GRP_W  = $clog2(N_GRP);
  localparam int IDX_W  = $clog2(N_IDX);
  localparam int N_TERM = N_GRP * N_IDX;

  // Register slot number: one slot per stride.
  function automatic int slot_of(input logic [ADDR_W-1:0] a);
    return int'(a[ADDR_W-1:STRIDE_LOG2]);
  endfunction

  // Only stride-aligned offsets are mapped.
  function automatic logic is_aligned(input logic [ADDR_W-1:0] a);
    return a[STRIDE_LOG2-1:0] == '0;
  endfunction

  logic [SLOT_W-1:0] slot;
  int                slot_n;

  assign slot   = addr[ADDR_W-1:STRIDE_LOG2];
  assign slot_n = slot_of(addr);

  always_comb begin
    kind = HIT_NONE;
    grp  = '0;
    idx  = '0;
    if (is_aligned(addr)) begin
      if (slot_n < N_TERM) begin
        kind = HIT_TERM;
        grp  = GRP_W'(slot >> IDX_W);
        idx  = slot[IDX_W-1:0];
      end else if (slot_n < N_TERM + N_GRP) begin
        kind = HIT_SUM;
        grp  = GRP_W'(slot - SLOT_W'(N_TERM));
      end
    end
  end

endmodule

// File: rtl/msi_term_group.sv
module msi_term_group #(
  parameter int N_IDX = 8,
  parameter int N_VEC = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       set_en,
  input  logic [$clog2(N_IDX)-1:0]   set_idx,
  input  logic [$clog2(N_VEC)-1:0]   set_bit,
  input  logic                       clr_en,
  input  logic [$clog2(N_IDX)-1:0]   clr_idx,
  output logic [N_IDX*N_VEC-1:0]     pend,
  output logic [N_IDX-1:0]           summary,
  output logic                       irq
);
  localparam int IDX_W = $clog2(N_IDX);

  for (genvar i = 0; i < N_IDX; i++) begin : g_idx
    logic [N_VEC-1:0] cur;
    logic [N_VEC-1:0] nxt;
    logic             hit_set;
    logic             hit_clr;

    assign hit_set = set_en && (set_idx == IDX_W'(i));
    assign hit_clr = clr_en && (clr_idx == IDX_W'(i));

    // Clear first, then set: a same-cycle arrival survives the read.
    always_comb begin
      nxt = cur;
      if (hit_clr) nxt = '0;
      if (hit_set) nxt[set_bit] = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst) cur <= '0;
      else     cur <= nxt;
    end

    assign pend[i*N_VEC +: N_VEC] = cur;
    assign summary[i]             = |cur;
  end

  assign irq = |summary;

endmodule

// File: rtl/msi_read_port.sv
module msi_read_port
  import msi_agg_pkg::*;
#(
  parameter int N_GRP = 16,
  parameter int N_IDX = 8,
  parameter int N_VEC = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          rd_en,
  input  hit_e                          kind,
  input  logic [$clog2(N_GRP)-1:0]      grp,
  input  logic [$clog2(N_IDX)-1:0]      idx,
  input  logic [N_GRP*N_IDX*N_VEC-1:0]  pend_all,
  input  logic [N_GRP*N_IDX-1:0]        summ_all,
  output logic [N_VEC-1:0]              rd_data,
  output logic                          rd_valid
);
  // Flat bit offset of an index register inside pend_all.
  function automatic int term_base(input logic [$clog2(N_GRP)-1:0] g,
                                   input logic [$clog2(N_IDX)-1:0] i);
    return (int'(g) * N_IDX + int'(i)) * N_VEC;
  endfunction

  logic [N_VEC-1:0] sel;

  always_comb begin
    sel = '0;
    case (kind)
      HIT_TERM: sel = pend_all[term_base(grp, idx) +: N_VEC];
      HIT_SUM:  sel = N_VEC'(summ_all[int'(grp) * N_IDX +: N_IDX]);
      default:  sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? sel : '0;
    end
  end

endmodule

// File: rtl/msi_pend_agg.sv
module msi_pend_agg
  import msi_agg_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 32,
  parameter int STRIDE_LOG2 = 16,
  parameter int N_GRP       = 16,
  parameter int N_IDX       = 8,
  parameter int N_VEC       = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [N_VEC-1:0]  rd_data,
  output logic              rd_valid,
  output logic [N_GRP-1:0]  irq
);
  localparam int GRP_W  = $clog2(N_GRP);
  localparam int IDX_W  = $clog2(N_IDX);
  localparam int BIT_W  = $clog2(N_VEC);
  localparam int N_TERM = N_GRP * N_IDX;
  localparam int SLOT_W = $clog2(N_TERM);

  hit_e             wr_kind, rd_kind;
  logic [GRP_W-1:0] wr_grp, rd_grp;
  logic [IDX_W-1:0] wr_idx, rd_idx;

  // Named events for the checker.
  logic              wr_term_hit;
  logic              rd_term_hit;
  logic              rd_sum_hit;
  logic [SLOT_W-1:0] wr_slot;
  logic [SLOT_W-1:0] rd_slot;

  logic [N_TERM*N_VEC-1:0] pend_flat;
  logic [N_TERM-1:0]       summ_flat;
  logic                    unused_data;

  assign unused_data = ^wr_data[DATA_W-1:BIT_W];

  msi_addr_decode #(
    .ADDR_W(ADDR_W), .STRIDE_LOG2(STRIDE_LOG2), .N_GRP(N_GRP), .N_IDX(N_IDX)
  ) u_wr_dec (
    .addr(wr_addr), .kind(wr_kind), .grp(wr_grp), .idx(wr_idx)
  );

  msi_addr_decode #(
    .ADDR_W(ADDR_W), .STRIDE_LOG2(STRIDE_LOG2), .N_GRP(N_GRP), .N_IDX(N_IDX)
  ) u_rd_dec (
    .addr(rd_addr), .kind(rd_kind), .grp(rd_grp), .idx(rd_idx)
  );

  assign wr_term_hit = wr_en && (wr_kind == HIT_TERM);
  assign rd_term_hit = rd_en && (rd_kind == HIT_TERM);
  assign rd_sum_hit  = rd_en && (rd_kind == HIT_SUM);
  assign wr_slot     = {wr_grp, wr_idx};
  assign rd_slot     = {rd_grp, rd_idx};

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    msi_term_group #(.N_IDX(N_IDX), .N_VEC(N_VEC)) u_grp (
      .clk     (clk),
      .rst     (rst),
      .set_en  (wr_term_hit && (wr_grp == GRP_W'(g))),
      .set_idx (wr_idx),
      .set_bit (wr_data[BIT_W-1:0]),
      .clr_en  (rd_term_hit && (rd_grp == GRP_W'(g))),
      .clr_idx (rd_idx),
      .pend    (pend_flat[g*N_IDX*N_VEC +: N_IDX*N_VEC]),
      .summary (summ_flat[g*N_IDX +: N_IDX]),
      .irq     (irq[g])
    );
  end

  msi_read_port #(.N_GRP(N_GRP), .N_IDX(N_IDX), .N_VEC(N_VEC)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .kind     (rd_kind),
    .grp      (rd_grp),
    .idx      (rd_idx),
    .pend_all (pend_flat),
    .summ_all (summ_flat),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

endmodule

// File: rtl/msi_agg_chk.sv
module msi_agg_chk #(
  parameter int N_GRP = 16,
  parameter int N_IDX = 8,
  parameter int N_VEC = 16
) (
  input logic                              clk,
  input logic                              rst,
  input logic                              wr_en,
  input logic                              rd_en,
  input logic                              wr_term_hit,
  input logic                              rd_term_hit,
  input logic                              rd_sum_hit,
  input logic [$clog2(N_GRP*N_IDX)-1:0]    wr_slot,
  input logic [$clog2(N_GRP*N_IDX)-1:0]    rd_slot,
  input logic [N_GRP*N_IDX*N_VEC-1:0]      pend_flat,
  input logic [N_VEC-1:0]                  rd_data,
  input logic                              rd_valid,
  input logic [N_GRP-1:0]                  irq
);
  localparam int SLOT_W = $clog2(N_GRP * N_IDX);

  logic [SLOT_W-1:0] prev_rd_slot;
  logic [SLOT_W-1:0] prev_wr_slot;
  logic [N_VEC-1:0]  rd_reg_now;
  logic [N_VEC-1:0]  prev_reg_after;
  logic              same_slot;

  always_ff @(posedge clk) begin
    prev_rd_slot <= rd_slot;
    prev_wr_slot <= wr_slot;
  end

  assign rd_reg_now     = pend_flat[int'(rd_slot) * N_VEC +: N_VEC];
  assign prev_reg_after = pend_flat[int'(prev_rd_slot) * N_VEC +: N_VEC];
  assign same_slot      = wr_term_hit && rd_term_hit && (wr_slot == rd_slot);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (irq == '0) && !rd_valid);

  // R5
  write_raises_irq_chk: assert property (@(posedge clk) disable iff (rst)
    wr_term_hit |=> irq[int'(prev_wr_slot) / N_IDX]);

  // R6
  read_clears_reg_chk: assert property (@(posedge clk) disable iff (rst)
    rd_term_hit && !same_slot |=> prev_reg_after == '0);

  // R6
  read_returns_old_chk: assert property (@(posedge clk) disable iff (rst)
    rd_term_hit |=> rd_data == $past(rd_reg_now));

  // R6
  valid_follows_en_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  // R6
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  // R7
  set_wins_clear_chk: assert property (@(posedge clk) disable iff (rst)
    same_slot |=> prev_reg_after != '0);

  // R8
  summary_read_stable_chk: assert property (@(posedge clk) disable iff (rst)
    rd_sum_hit && !wr_term_hit |=> $stable(pend_flat));

  // R9
  ignored_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && !wr_term_hit && !rd_term_hit |=> $stable(pend_flat));

  // R4
  summary_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_sum_hit |=> rd_data[N_VEC-1:N_IDX] == '0);

endmodule

bind msi_pend_agg msi_agg_chk #(
  .N_GRP(N_GRP), .N_IDX(N_IDX), .N_VEC(N_VEC)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .wr_term_hit (wr_term_hit),
  .rd_term_hit (rd_term_hit),
  .rd_sum_hit  (rd_sum_hit),
  .wr_slot     (wr_slot),
  .rd_slot     (rd_slot),
  .pend_flat   (pend_flat),
  .rd_data     (rd_data),
  .rd_valid    (rd_valid),
  .irq         (irq)
);

// File: tb/tb_msi_pend_agg.sv
module tb_msi_pend_agg;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [23:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [23:0] rd_addr = '0;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic [15:0] irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [15:0] mdl [0:127];
  logic [15:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_pend_agg dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .irq(irq)
  );

  function automatic logic [23:0] idx_addr(input int g, input int i);
    return 24'((g * 8 + i) * 'h10000);
  endfunction

  function automatic logic [23:0] sum_addr(input int g);
    return 24'('h800000 + g * 'h10000);
  endfunction

  // 0 = unmapped, 1 = index register, 2 = summary; slot returned by ref.
  function automatic int classify(input logic [23:0] a, output int slot);
    int q;
    q    = int'(a) / 'h10000;
    slot = q;
    if ((int'(a) % 'h10000) != 0) return 0;
    if (q < 128) return 1;
    if (q < 144) begin slot = q - 128; return 2; end
    return 0;
  endfunction

  function automatic logic [15:0] model_read(input int k, input int s);
    logic [15:0] r;
    r = '0;
    if (k == 1) r = mdl[s];
    else if (k == 2)
      for (int i = 0; i < 8; i++) r[i] = (mdl[s * 8 + i] != 16'h0);
    return r;
  endfunction

  function automatic logic [15:0] model_irq();
    logic [15:0] r;
    r = '0;
    for (int g = 0; g < 16; g++)
      for (int i = 0; i < 8; i++)
        if (mdl[g * 8 + i] != 16'h0) r[g] = 1'b1;
    return r;
  endfunction

  task automatic step(input bit we, input logic [23:0] wa, input logic [31:0] wd,
                      input bit re, input logic [23:0] ra, input string tag);
    int wk, ws, rk, rs;
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd;
    rd_en = re; rd_addr = ra;
    wk = classify(wa, ws);
    rk = classify(ra, rs);
    if (re) begin
      exp_q.push_back(model_read(rk, rs));
      tag_q.push_back(tag);
    end
    if (re && rk == 1) mdl[rs] = '0;
    if (we && wk == 1) mdl[ws][wd[3:0]] = 1'b1;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    step(1'b0, '0, '0, 1'b0, '0, "");
  endtask

  task automatic wr(input logic [23:0] a, input logic [31:0] d, input string tag);
    step(1'b1, a, d, 1'b0, '0, tag);
  endtask

  task automatic rd(input logic [23:0] a, input string tag);
    step(1'b0, '0, '0, 1'b1, a, tag);
  endtask

  task automatic check_irq(input string tag);
    logic [15:0] e;
    e = model_irq();
    n_cmp++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s irq actual=%h expected=%h", tag, irq, e);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    @(posedge clk);
    #1;
    for (int s = 0; s < 128; s++) mdl[s] = '0;
    n_cmp++;
    if (irq !== 16'h0 || rd_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 irq/rd_valid actual=%h/%b expected=0000/0", irq, rd_valid);
    end
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R6 rd_valid with no read outstanding actual=1 expected=0");
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (rd_data !== e) begin
          n_bad++;
          $display("FAIL %s rd_data actual=%h expected=%h", t, rd_data, e);
        end
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 128; s++) mdl[s] = '0;
    repeat (3) @(posedge clk);
    do_reset();

    // R5 R2: single vector in group 3, index 5, bit 9
    wr(idx_addr(3, 5), 32'd9, "R2");
    check_irq("R5");
    // R4 summary shows index 5
    rd(sum_addr(3), "R4");
    // R8 summary read twice, nothing changes
    rd(sum_addr(3), "R8");
    check_irq("R8");
    // R6 read-clear
    rd(idx_addr(3, 5), "R6");
    check_irq("R6");
    rd(idx_addr(3, 5), "R6");
    rd(sum_addr(3), "R6");

    // R2 upper data bits ignored
    wr(idx_addr(7, 0), 32'hFFFF_FFF3, "R2");
    check_irq("R2");
    rd(idx_addr(7, 0), "R2");

    // R3 duplicate set
    wr(idx_addr(1, 2), 32'd4, "R3");
    wr(idx_addr(1, 2), 32'd4, "R3");
    check_irq("R3");
    rd(sum_addr(1), "R3");
    rd(idx_addr(1, 2), "R3");

    // R7 write and read-clear of the same register in one cycle
    wr(idx_addr(9, 6), 32'd2, "R7");
    step(1'b1, idx_addr(9, 6), 32'd7, 1'b1, idx_addr(9, 6), "R7");
    check_irq("R7");
    rd(idx_addr(9, 6), "R7");
    check_irq("R7");

    // R9 ignored writes, unmapped reads
    wr(sum_addr(4), 32'd1, "R9");
    wr(idx_addr(4, 0) + 24'h4, 32'd1, "R9");
    wr(24'h900000, 32'd1, "R9");
    wr(24'hFF0000, 32'd1, "R9");
    check_irq("R9");
    rd(idx_addr(4, 0), "R9");
    rd(24'h900000, "R9");
    rd(idx_addr(2, 2) + 24'h0100, "R9");

    // R4 several index registers in group 15
    wr(idx_addr(15, 0), 32'd0, "R4");
    wr(idx_addr(15, 2), 32'd15, "R4");
    wr(idx_addr(15, 7), 32'd8, "R4");
    rd(sum_addr(15), "R4");
    rd(idx_addr(15, 2), "R4");
    rd(sum_addr(15), "R4");
    check_irq("R5");
    rd(idx_addr(15, 0), "R6");
    rd(idx_addr(15, 7), "R6");
    check_irq("R6");

    // R10 vector sweep including both ends
    for (int v = 0; v < 2048; v += 37) begin
      int n, x;
      n = v / 256;
      x = (v % 256) / 16;
      wr(idx_addr(x, n), 32'(v % 16), "R10");
      check_irq("R10");
      rd(idx_addr(x, n), "R10");
    end
    wr(idx_addr(15, 7), 32'd15, "R10");
    check_irq("R10");
    rd(idx_addr(15, 7), "R10");

    // R1 reset in the middle of traffic
    wr(idx_addr(0, 0), 32'd1, "R1");
    wr(idx_addr(12, 3), 32'd5, "R1");
    idle();
    idle();
    do_reset();
    rd(idx_addr(12, 3), "R1");
    rd(sum_addr(0), "R1");
    check_irq("R1");

    repeat (3) idle();
    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R6 reads left unanswered actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule